// File: doc/BRIEF.md
# Bus-Paced Response Bit Serializer

This block returns a slave's prepared reply to the bus master one bit at a time. It switches a current-sink enable on for a 1 bit and leaves it off for a 0 bit. It has no bit clock of its own. The master's signaling waveform sets the pace: each time the bus falls from the signal-high level to the signal-low level inside a frame, the next reply bit is presented. The sink is always forced off while the bus rests at its idle level, so a return to idle ends the reply.

The command logic captures a reply with a load strobe. A reply is either a long word (16 data bits and a 4-bit check code) or a short word (8 data bits and the same 4-bit check code). A quiet load marks the next frame as one with no reply. A load that arrives while a frame is in progress is held back until the bus is idle again. A one-cycle done pulse marks the moment the last loaded bit is placed on the sink enable.

Top module: `resp_bit_serializer`

## Requirements
- R1: After reset, `sink_en` and `done` are 0 and no reply is pending.
- R2: `bus_lvl` encodes the bus state as 2'b00 idle, 2'b01 signal high, 2'b10 signal low, and 2'b11, which is treated as idle. When the bus leaves idle, the first high-to-low transition presents reply bit 0 on `sink_en`.
- R3: Each later high-to-low transition presents the next reply bit. While the bus is not idle and no such transition occurs, `sink_en` holds its value, and this includes the high phase.
- R4: `sink_en` is 0 whenever the synchronized bus level is idle. A return to idle ends the reply and consumes it, so the next frame sends nothing unless a new load arrives.
- R5: A 1 bit turns the sink on and a 0 bit leaves it off. A long reply sends `ld_data[15]` down to `ld_data[0]`, then `ld_crc[3]` down to `ld_crc[0]` (20 bits). A short reply sends `ld_data[7]` down to `ld_data[0]`, then `ld_crc[3]` down to `ld_crc[0]` (12 bits).
- R6: Any bit the master clocks past the loaded length is sent as 0.
- R7: When no reply is pending, `sink_en` stays 0 for the whole frame. No reply is pending when nothing was loaded, or when the last load had `ld_quiet` = 1. A quiet load cancels a reply that was loaded earlier and not yet sent.
- R8: A load taken while the bus is not idle does not change the frame in progress. Its word is used from the next frame on.
- R9: `done` is high for exactly one cycle, in the cycle where the last loaded bit appears on `sink_en`. A frame that ends before that point, or a frame with no reply, gives no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_lvl | input | 2 | Three-level bus state from the level detector |
| ld_stb | input | 1 | Capture strobe for a reply |
| ld_data | input | DATA_LONG | Reply data; only the low DATA_SHORT bits are used for a short reply |
| ld_crc | input | CRC_W | Check code sent after the data |
| ld_long | input | 1 | 1 selects the long format, 0 the short format |
| ld_quiet | input | 1 | 1 marks the next frame as one with no reply |
| sink_en | output | 1 | Current-sink enable |
| done | output | 1 | One-cycle pulse when the last loaded bit is presented |

## Verification
The assertions check, on every cycle, that the sink is off at idle, that the sink is held steady between falling transitions, that it stays off when no reply is armed, and that `done` is a single-cycle pulse tied to a falling transition. Only the bench scenarios can show the following: the bit order of both formats, zero padding past the length, deferral of a load made in mid-frame, a quiet load cancelling a pending reply, and whether `done` appears at the right bit count.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
   localparam logic [1:0] LV_IDLE     = 2'b00;
   localparam logic [1:0] LV_HIGH     = 2'b01;
   localparam logic [1:0] LV_LOW      = 2'b10;
   localparam logic [1:0] LV_IDLE_ALT = 2'b11;

   function automatic logic lvl_is_idle(input logic [1:0] lvl);
      return (lvl == LV_IDLE) || (lvl == LV_IDLE_ALT);
   endfunction
endpackage

// File: rtl/rbs_level_sync.sv
module rbs_level_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] bus_lvl,
   output logic       idle_now,
   output logic       fall,
   output logic       frame_end
);
   import rbs_pkg::*;

   logic [1:0] chain [SYNC_STAGES];
   logic [1:0] lvl_now;
   logic [1:0] lvl_prev;

   generate
      if (SYNC_STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= LV_IDLE;
            else        chain[0] <= bus_lvl;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < SYNC_STAGES; k++) chain[k] <= LV_IDLE;
            end else begin
               chain[0] <= bus_lvl;
               for (int k = 1; k < SYNC_STAGES; k++) chain[k] <= chain[k-1];
            end
         end
      end
   endgenerate

   assign lvl_now = chain[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_prev <= LV_IDLE;
      else        lvl_prev <= lvl_now;
   end

   assign idle_now  = lvl_is_idle(lvl_now);
   assign fall      = (lvl_prev == LV_HIGH) && (lvl_now == LV_LOW);
   assign frame_end = !lvl_is_idle(lvl_prev) && idle_now;
endmodule

// File: rtl/rbs_word_stage.sv
module rbs_word_stage #(
   parameter int DATA_LONG  = 16,
   parameter int DATA_SHORT = 8,
   parameter int CRC_W      = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ld_stb,
   input  logic [DATA_LONG-1:0] ld_data,
   input  logic [CRC_W-1:0]     ld_crc,
   input  logic                 ld_long,
   input  logic                 ld_quiet,
   input  logic                 idle_now,
   input  logic                 fall,
   input  logic                 frame_end,
   output logic                 armed,
   output logic                 cur_bit,
   output logic                 last_bit
);
   localparam int WORD_W  = DATA_LONG + CRC_W;
   localparam int SHORT_W = DATA_SHORT + CRC_W;
   localparam int PAD_W   = DATA_LONG - DATA_SHORT;
   localparam int CNT_W   = $clog2(WORD_W + 2);
   localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(SHORT_W);

   logic [WORD_W-1:0] img_long, img_short, img_sel;
   logic [WORD_W-1:0] stg_img, sh_q;
   logic [CNT_W-1:0]  stg_len, len_q, cnt_q;
   logic              stg_quiet, stg_v, transfer;

   assign img_long  = {ld_data, ld_crc};
   assign img_short = {ld_data[DATA_SHORT-1:0], ld_crc, {PAD_W{1'b0}}};
   assign img_sel   = ld_long ? img_long : img_short;

   // Staging: a load waits here until the bus is idle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_img   <= '0;
         stg_len   <= '0;
         stg_quiet <= 1'b1;
         stg_v     <= 1'b0;
      end else if (ld_stb) begin
         stg_img   <= img_sel;
         stg_len   <= ld_long ? LEN_LONG : LEN_SHORT;
         stg_quiet <= ld_quiet;
         stg_v     <= 1'b1;
      end else if (transfer) begin
         stg_v     <= 1'b0;
      end
   end

   assign transfer = stg_v && idle_now;

   // Active shift image: advances on every high-to-low transition.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         len_q <= '0;
         cnt_q <= '0;
         armed <= 1'b0;
      end else if (transfer) begin
         sh_q  <= stg_img;
         len_q <= stg_len;
         cnt_q <= '0;
         armed <= !stg_quiet;
      end else if (frame_end) begin
         sh_q  <= '0;
         cnt_q <= '0;
         armed <= 1'b0;
      end else if (fall && armed) begin
         sh_q <= {sh_q[WORD_W-2:0], 1'b0};
         if (cnt_q != LEN_LONG) cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign cur_bit  = armed && sh_q[WORD_W-1];
   assign last_bit = armed && ((cnt_q + CNT_W'(1)) == len_q);
endmodule

// File: rtl/rbs_bit_driver.sv
module rbs_bit_driver (
   input  logic clk,
   input  logic rst_n,
   input  logic idle_now,
   input  logic fall,
   input  logic cur_bit,
   input  logic last_bit,
   output logic sink_q,
   output logic done_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sink_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= fall && last_bit;
         if (idle_now)  sink_q <= 1'b0;
         else if (fall) sink_q <= cur_bit;
      end
   end
endmodule

// File: rtl/resp_bit_serializer.sv
module resp_bit_serializer #(
   parameter int DATA_LONG   = 16,
   parameter int DATA_SHORT  = 8,
   parameter int CRC_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           bus_lvl,
   input  logic                 ld_stb,
   input  logic [DATA_LONG-1:0] ld_data,
   input  logic [CRC_W-1:0]     ld_crc,
   input  logic                 ld_long,
   input  logic                 ld_quiet,
   output logic                 sink_en,
   output logic                 done
);
   generate
      if (DATA_SHORT < 1 || DATA_SHORT >= DATA_LONG) begin : g_bad_len
         $error("DATA_SHORT must lie in 1..DATA_LONG-1");
      end
      if (CRC_W < 1) begin : g_bad_crc
         $error("CRC_W must be at least 1");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 1..4");
      end
   endgenerate

   logic idle_now, fall, frame_end;
   logic armed, cur_bit, last_bit;
   logic sink_q, done_q;

   rbs_level_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .bus_lvl(bus_lvl),
      .idle_now(idle_now), .fall(fall), .frame_end(frame_end)
   );

   rbs_word_stage #(.DATA_LONG(DATA_LONG), .DATA_SHORT(DATA_SHORT), .CRC_W(CRC_W)) u_word (
      .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_data(ld_data),
      .ld_crc(ld_crc), .ld_long(ld_long), .ld_quiet(ld_quiet),
      .idle_now(idle_now), .fall(fall), .frame_end(frame_end),
      .armed(armed), .cur_bit(cur_bit), .last_bit(last_bit)
   );

   rbs_bit_driver u_drv (
      .clk(clk), .rst_n(rst_n), .idle_now(idle_now), .fall(fall),
      .cur_bit(cur_bit), .last_bit(last_bit), .sink_q(sink_q), .done_q(done_q)
   );

   assign sink_en = sink_q && !idle_now;
   assign done    = done_q;
endmodule

// File: rtl/rbs_checker.sv
module rbs_checker (
   input logic clk,
   input logic rst_n,
   input logic idle_now,
   input logic fall,
   input logic armed,
   input logic sink_q,
   input logic sink_en,
   input logic done
);
   p_idle_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      idle_now |-> !sink_en);

   p_hold_between_falls_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!fall && !idle_now) |=> $stable(sink_q));

   p_quiet_when_unarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !sink_q);

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(fall));
endmodule

bind resp_bit_serializer rbs_checker u_rbs_checker (
   .clk(clk), .rst_n(rst_n), .idle_now(idle_now), .fall(fall),
   .armed(armed), .sink_q(sink_q), .sink_en(sink_en), .done(done)
);

// File: tb/test_resp_bit_serializer.sv
module test_resp_bit_serializer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_lvl = 2'b00;
   logic        ld_stb = 1'b0;
   logic [15:0] ld_data = '0;
   logic [3:0]  ld_crc = '0;
   logic        ld_long = 1'b0;
   logic        ld_quiet = 1'b0;
   logic        sink_en, done;

   int checks = 0;
   int errors = 0;
   int done_cnt = 0;

   always #5 clk = ~clk;

   resp_bit_serializer i_resp_bit_serializer (
      .clk(clk), .rst_n(rst_n), .bus_lvl(bus_lvl), .ld_stb(ld_stb),
      .ld_data(ld_data), .ld_crc(ld_crc), .ld_long(ld_long),
      .ld_quiet(ld_quiet), .sink_en(sink_en), .done(done)
   );

   always @(negedge clk) if (done === 1'b1) done_cnt++;

   task automatic chk(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic exp_bit(input logic [15:0] d, input logic [3:0] c,
                                    input bit lng, input int i);
      logic [19:0] img;
      int len;
      if (lng) begin img = {d, c}; len = 20; end
      else begin img = {d[7:0], c, 8'h00}; len = 12; end
      if (i >= len) return 1'b0;
      return img[19-i];
   endfunction

   task automatic hold(input logic [1:0] l, input int n);
      bus_lvl = l;
      repeat (n) @(negedge clk);
   endtask

   task automatic load(input logic [15:0] d, input logic [3:0] c, input bit lng, input bit q);
      ld_data = d; ld_crc = c; ld_long = lng; ld_quiet = q; ld_stb = 1'b1;
      @(negedge clk);
      ld_stb = 1'b0;
   endtask

   // Runs one master frame of nbits bit periods, then returns to idle with idle_code.
   task automatic run_frame(input int nbits, input bit act, input logic [15:0] d,
                            input logic [3:0] c, input bit lng, input logic [1:0] idle_code);
      logic prev = 1'b0;
      int   len = lng ? 20 : 12;
      done_cnt = 0;
      for (int i = 0; i < nbits; i++) begin
         hold(2'b01, 5);
         chk("R3", sink_en, prev, $sformatf("hold during high before bit %0d", i));
         hold(2'b10, 5);
         prev = act ? exp_bit(d, c, lng, i) : 1'b0;
         if (!act)         chk("R7", sink_en, prev, $sformatf("silent bit %0d", i));
         else if (i >= len) chk("R6", sink_en, prev, $sformatf("pad bit %0d", i));
         else if (i == 0)  chk("R2", sink_en, prev, "first bit");
         else              chk("R5", sink_en, prev, $sformatf("bit %0d", i));
      end
      hold(idle_code, 5);
      chk("R4", sink_en, 1'b0, "idle forces sink off");
      chk("R9", logic'(done_cnt == ((act && nbits >= len) ? 1 : 0)), 1'b1,
          $sformatf("done count %0d", done_cnt));
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] d, d2;
      logic [3:0]  c, c2;
      bit          lng;
      void'($urandom(32'h5A17));
      repeat (3) @(negedge clk);
      chk("R1", sink_en, 1'b0, "reset sink");
      chk("R1", done, 1'b0, "reset done");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1/R7: nothing loaded yet, frame stays silent
      run_frame(6, 1'b0, 16'h0, 4'h0, 1'b1, 2'b00);

      // R5/R6/R9: long reply plus two padding bits
      load(16'hB5C3, 4'hA, 1'b1, 1'b0); hold(2'b00, 3);
      run_frame(22, 1'b1, 16'hB5C3, 4'hA, 1'b1, 2'b00);

      // R4: reply consumed, next frame silent
      run_frame(4, 1'b0, 16'h0, 4'h0, 1'b1, 2'b00);

      // R5/R6: short reply
      load(16'hFF9D, 4'h7, 1'b0, 1'b0); hold(2'b00, 3);
      run_frame(14, 1'b1, 16'hFF9D, 4'h7, 1'b0, 2'b00);

      // R7: quiet load cancels pending reply
      load(16'hFFFF, 4'hF, 1'b1, 1'b0);
      load(16'h0000, 4'h0, 1'b1, 1'b1); hold(2'b00, 3);
      run_frame(8, 1'b0, 16'h0, 4'h0, 1'b1, 2'b00);

      // R2/R4/R9: early end through the alternate idle code, no done
      load(16'hFFFF, 4'hF, 1'b1, 1'b0); hold(2'b00, 3);
      run_frame(5, 1'b1, 16'hFFFF, 4'hF, 1'b1, 2'b11);
      hold(2'b00, 3);
      run_frame(3, 1'b0, 16'h0, 4'h0, 1'b1, 2'b00);

      // R8: load during a frame is deferred
      load(16'h8000, 4'h1, 1'b1, 1'b0); hold(2'b00, 3);
      done_cnt = 0;
      hold(2'b01, 5); hold(2'b10, 5);
      chk("R8", sink_en, 1'b1, "old word bit 0");
      load(16'h0000, 4'h0, 1'b0, 1'b0);
      hold(2'b01, 5); hold(2'b10, 5);
      chk("R8", sink_en, 1'b0, "old word bit 1 after mid-frame load");
      hold(2'b00, 5);
      run_frame(12, 1'b1, 16'h0000, 4'h0, 1'b0, 2'b00);
      load(16'h00F0, 4'h9, 1'b0, 1'b0); hold(2'b00, 3);
      run_frame(12, 1'b1, 16'h00F0, 4'h9, 1'b0, 2'b00);

      // Random mix
      for (int n = 0; n < 30; n++) begin
         d = 16'($urandom); c = 4'($urandom); lng = 1'($urandom);
         if ($urandom_range(0, 4) == 0) begin
            load(d, c, lng, 1'b1); hold(2'b00, 3);
            run_frame($urandom_range(1, 10), 1'b0, d, c, lng, 2'b00);
         end else begin
            load(d, c, lng, 1'b0); hold(2'b00, 3);
            d2 = 16'($urandom); c2 = 4'($urandom);
            if ($urandom_range(0, 3) == 0) begin
               load(d2, c2, lng, 1'b0); hold(2'b00, 3);
               d = d2; c = c2;
            end
            run_frame($urandom_range(1, 22), 1'b1, d, c, lng,
                      ($urandom_range(0, 1) == 1) ? 2'b11 : 2'b00);
            hold(2'b00, 2);
         end
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule